// File: doc/BRIEF.md
# Oversampled Serial Byte Transceiver with Address Filter

This block sends and receives asynchronous serial frames of ten bits: a low start bit, eight data bits sent least significant bit first, and a high stop bit. A baud tick input pulses once per clock at sixteen times the bit rate. Each bit therefore lasts sixteen ticks. The transmitter places each frame on a free-running sixteen-tick grid. It uses a sentinel bit in its shift register to detect when the frame is complete, and then raises a done flag.

The receiver watches the line once per tick. A falling edge starts a frame, but only if the receiver has already seen the line high. The edge restarts the receiver's sixteen-tick count. Every bit, the start bit included, is decided by a two-of-three vote over ticks 7, 8 and 9 of its bit period. If the start bit votes high, the receiver drops the frame and waits for a new edge.

When a frame completes, the byte is kept only if two things hold. The receive flag must be clear. Also, either the address filter input must be low or the received stop bit must be high. If the byte is kept, it goes to the data output, the stop bit goes to a separate flag, and the receive flag rises. Otherwise the byte is lost.

The transmit side is a valid/ready input. Back-pressure is plain: `tx_ready` is low for the whole of a frame, and a `tx_valid` offered while `tx_ready` is low has no effect. The receive side has no back-pressure. `rx_valid` stays high until `rx_take` clears it, and any frame that completes while `rx_valid` is high is dropped.

Top module: `uart_mp_top`

## Requirements
- R1: After reset, `txd` = 1, `tx_ready` = 1, `tx_done` = 0, `rx_valid` = 0, `rx_data` = 8'h00 and `rx_stop` = 0.
- R2: A byte is accepted at a clock edge where `tx_valid` and `tx_ready` are both 1. `tx_ready` is 0 from the next cycle until the frame ends. A `tx_valid` offered while `tx_ready` is 0 changes nothing.
- R3: The transmit tick counter counts baud ticks from reset and rolls over on every 16th tick. After an accepted byte, `txd` goes to 0 at the first rollover. At each later rollover `txd` moves to the next bit: data bit 0 through data bit 7, then a 1 for the stop bit. While the transmitter is idle, `txd` is 1.
- R4: At the rollover that ends the stop bit, `tx_done` becomes 1 and `tx_ready` becomes 1 in the same cycle.
- R5: When idle, the receiver starts a frame at a tick that samples `rxd` = 0, if the previous tick sampled `rxd` = 1. That tick becomes count 0 of the start bit.
- R6: Each bit's value is the majority of the `rxd` samples taken at counts 7, 8 and 9 of its 16-tick period. A single sample that differs from the other two does not change the decided value.
- R7: If the start bit decides 1, the frame is abandoned. The receiver then waits for a new high sample followed by a low one, and no flag or output changes.
- R8: When the stop bit is decided and the byte is kept, `rx_data` takes the eight data bits (first received bit in bit 0), `rx_stop` takes the stop bit value and `rx_valid` becomes 1, all in the same cycle.
- R9: A frame that completes while `rx_valid` = 1 is discarded, and `rx_data` and `rx_stop` stay unchanged.
- R10: With `addr_filter` = 1, a frame whose stop bit decides 0 is discarded. A frame whose stop bit decides 1 is kept.
- R11: After a frame is completed or abandoned, the receiver does not start a new frame until it has sampled `rxd` = 1 on at least one tick.
- R12: `rx_take` = 1 clears `rx_valid` on the next edge. `tx_done_clr` = 1 clears `tx_done` on the next edge. When a set and a clear of the same flag meet in one cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Byte on `tx_data` is offered |
| tx_ready | output | 1 | Transmitter idle and able to take a byte |
| txd | output | 1 | Serial output, idles high |
| tx_done | output | 1 | Sticky flag: a frame has been sent |
| tx_done_clr | input | 1 | Clears `tx_done` |
| rxd | input | 1 | Serial input, synchronous to `clk` |
| addr_filter | input | 1 | When 1, frames with a low stop bit are dropped |
| rx_take | input | 1 | Clears `rx_valid` |
| rx_data | output | 8 | Last kept byte |
| rx_valid | output | 1 | Sticky flag: a byte is held in `rx_data` |
| rx_stop | output | 1 | Stop bit value of the last kept frame |

## Verification
The hardest case to reach from the ports is the re-arm rule. A frame whose stop bit is only about ten ticks long is followed at once by a long low stretch, so the line never reads high between the two. The bench drives `rxd` tick by tick for this. It follows with a clean frame, which is received correctly only if the low stretch was ignored. Start bits that fail the vote are produced the same way: the line is held low for a controlled number of ticks, so that one sample position, or the whole vote, reads high. A reference model, stepped on every clock, tracks every output throughout the run.

// File: rtl/uart_mp_pkg.sv
package uart_mp_pkg;

  typedef enum logic {
    RX_HUNT = 1'b0,
    RX_RECV = 1'b1
  } rx_state_t;

  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/uart_mp_tx.sv
module uart_mp_tx #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              txd,
  output logic              tx_done,
  input  logic              tx_done_clr
);

  localparam int CW = $clog2(OVS);
  localparam int SW = DATA_W + 1;

  logic [CW-1:0] div_q;
  logic          roll;
  logic          busy_q, started_q, txd_q, done_q;
  logic [SW-1:0] sh_q;
  logic          accept, finish;

  assign roll   = baud_tick && (div_q == CW'(OVS - 1));
  assign accept = tx_valid && !busy_q;
  // sentinel drained: the stop bit has been on the line for a full period
  assign finish = busy_q && roll && started_q && (sh_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         div_q <= '0;
    else if (baud_tick) div_q <= div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      started_q <= 1'b0;
      sh_q      <= '0;
      txd_q     <= 1'b1;
    end else if (accept) begin
      sh_q      <= {1'b1, tx_data};
      busy_q    <= 1'b1;
      started_q <= 1'b0;
    end else if (busy_q && roll) begin
      if (!started_q) begin
        txd_q     <= 1'b0;
        started_q <= 1'b1;
      end else if (finish) begin
        busy_q    <= 1'b0;
      end else begin
        txd_q     <= sh_q[0];
        sh_q      <= {1'b0, sh_q[SW-1:1]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           done_q <= 1'b0;
    else if (finish)      done_q <= 1'b1;
    else if (tx_done_clr) done_q <= 1'b0;
  end

  assign tx_ready = !busy_q;
  assign txd      = txd_q;
  assign tx_done  = done_q;

  p_ready_drops_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  p_idle_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> txd);

  p_done_with_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_done) |-> tx_ready);

  p_done_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done_clr && !finish) |=> !tx_done);

endmodule

// File: rtl/uart_mp_rx.sv
module uart_mp_rx
  import uart_mp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              rxd,
  input  logic              addr_filter,
  input  logic              rx_take,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_stop
);

  localparam int CW  = $clog2(OVS);
  localparam int FW  = DATA_W + 2;
  localparam int MID = OVS / 2;
  localparam int SA  = MID - 1;
  localparam int SB  = MID;
  localparam int SC  = MID + 1;

  rx_state_t         st_q;
  logic              armed_q, samp_a, samp_b;
  logic [CW-1:0]     cnt_q, cnt_nx;
  logic [FW-1:0]     sh_q, sh_nx;
  logic              vote, decide, false_start, frame_end, keep;
  logic [DATA_W-1:0] data_q;
  logic              valid_q, stop_q;

  assign cnt_nx      = cnt_q + 1'b1;
  assign vote        = vote3(samp_a, samp_b, rxd);
  assign sh_nx       = {vote, sh_q[FW-1:1]};
  assign decide      = baud_tick && (st_q == RX_RECV) && (cnt_nx == CW'(SC));
  // register still all ones means this decision is the start bit's
  assign false_start = decide && (&sh_q) && vote;
  // start-bit zero has walked to bit 0: the stop bit was just shifted in
  assign frame_end   = decide && !false_start && !sh_nx[0];
  assign keep        = frame_end && !valid_q && (!addr_filter || vote);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= RX_HUNT;
      armed_q <= 1'b0;
      cnt_q   <= '0;
      samp_a  <= 1'b0;
      samp_b  <= 1'b0;
      sh_q    <= '1;
    end else if (baud_tick) begin
      if (st_q == RX_HUNT) begin
        if (armed_q && !rxd) begin
          st_q    <= RX_RECV;
          cnt_q   <= '0;
          sh_q    <= '1;
          armed_q <= 1'b0;
        end else begin
          armed_q <= rxd;
        end
      end else begin
        cnt_q <= cnt_nx;
        if (cnt_nx == CW'(SA)) samp_a <= rxd;
        if (cnt_nx == CW'(SB)) samp_b <= rxd;
        if (false_start || frame_end) begin
          st_q    <= RX_HUNT;
          armed_q <= 1'b0;
        end else if (decide) begin
          sh_q    <= sh_nx;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      stop_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      if (keep) begin
        data_q  <= sh_nx[DATA_W:1];
        stop_q  <= sh_nx[FW-1];
        valid_q <= 1'b1;
      end else if (rx_take) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign rx_data  = data_q;
  assign rx_valid = valid_q;
  assign rx_stop  = stop_q;

  p_hold_when_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_take) |=> ($stable(rx_data) && $stable(rx_stop)));

  p_filter_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rx_valid) && $past(addr_filter)) |-> rx_stop);

  p_take_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_take) |=> !rx_valid);

  p_no_rearm_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (false_start || frame_end) |=> (st_q == RX_HUNT) && !armed_q);

endmodule

// File: rtl/uart_mp_top.sv
module uart_mp_top #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              txd,
  output logic              tx_done,
  input  logic              tx_done_clr,
  input  logic              rxd,
  input  logic              addr_filter,
  input  logic              rx_take,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_stop
);

  uart_mp_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .baud_tick   (baud_tick),
    .tx_data     (tx_data),
    .tx_valid    (tx_valid),
    .tx_ready    (tx_ready),
    .txd         (txd),
    .tx_done     (tx_done),
    .tx_done_clr (tx_done_clr)
  );

  uart_mp_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .baud_tick   (baud_tick),
    .rxd         (rxd),
    .addr_filter (addr_filter),
    .rx_take     (rx_take),
    .rx_data     (rx_data),
    .rx_valid    (rx_valid),
    .rx_stop     (rx_stop)
  );

endmodule

// File: tb/uart_mp_top_tb_top.sv
module uart_mp_top_tb_top;

  localparam int CLK_P   = 10;
  localparam int WD_LIM  = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_valid = 1'b0;
  logic       tx_ready, txd, tx_done;
  logic       tx_done_clr = 1'b0;
  logic       rxd;
  logic       addr_filter = 1'b0;
  logic       rx_take = 1'b0;
  logic [7:0] rx_data;
  logic       rx_valid, rx_stop;

  logic loop_en = 1'b0;
  logic rx_drv  = 1'b1;
  assign rxd = loop_en ? txd : rx_drv;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  uart_mp_top dut_i (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .txd(txd), .tx_done(tx_done), .tx_done_clr(tx_done_clr),
    .rxd(rxd), .addr_filter(addr_filter), .rx_take(rx_take),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_stop(rx_stop)
  );

  always #(CLK_P/2) clk = ~clk;

  int tcnt = 0;
  always @(negedge clk) begin
    baud_tick <= (tcnt == 2);
    tcnt      <= (tcnt + 1) % 3;
  end

  // ---------------- behavioural reference model ----------------
  int         m_div, m_busy, m_phase;
  logic [7:0] m_tdata;
  logic       m_txd, m_ti;
  int         m_recv, m_armed, m_idx, m_bit, s7, s8;
  logic [9:0] m_bits;
  logic       m_ri, m_rb8, old_ri, v;
  logic [7:0] m_rdata;
  bit         acc;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_div = 0; m_busy = 0; m_phase = -1; m_tdata = 0; m_txd = 1; m_ti = 0;
      m_recv = 0; m_armed = 0; m_idx = 0; m_bit = 0; s7 = 0; s8 = 0;
      m_bits = 0; m_ri = 0; m_rb8 = 0; m_rdata = 0;
    end else begin
      acc = tx_valid && (m_busy == 0);
      if (tx_done_clr) m_ti = 0;
      if (m_busy != 0 && baud_tick && m_div == 15) begin
        if (m_phase < 0) begin
          m_txd = 0; m_phase = 0;
        end else if (m_phase < 9) begin
          m_phase++;
          m_txd = (m_phase <= 8) ? m_tdata[m_phase-1] : 1'b1;
        end else begin
          m_busy = 0; m_ti = 1;
        end
      end
      if (baud_tick) m_div = (m_div + 1) % 16;
      if (acc) begin m_busy = 1; m_phase = -1; m_tdata = tx_data; end

      old_ri = m_ri;
      if (rx_take) m_ri = 0;
      if (baud_tick) begin
        if (m_recv == 0) begin
          if (m_armed != 0 && !rxd) begin
            m_recv = 1; m_idx = 0; m_bit = 0;
          end else m_armed = rxd;
        end else begin
          m_idx = (m_idx + 1) % 16;
          if (m_idx == 7) s7 = rxd;
          if (m_idx == 8) s8 = rxd;
          if (m_idx == 9) begin
            v = ((s7 + s8 + int'(rxd)) >= 2);
            if (m_bit == 0 && v) begin
              m_recv = 0; m_armed = 0;
            end else begin
              m_bits[m_bit] = v;
              if (m_bit == 9) begin
                if (!old_ri && (!addr_filter || v)) begin
                  m_rdata = m_bits[8:1]; m_rb8 = v; m_ri = 1;
                end
                m_recv = 0; m_armed = 0;
              end else m_bit++;
            end
          end
        end
      end
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R3", "txd model",      txd,      m_txd);
      chk("R2", "tx_ready model", tx_ready, !m_busy);
      chk("R4", "tx_done model",  tx_done,  m_ti);
      chk("R8", "rx_valid model", rx_valid, m_ri);
      chk("R8", "rx_data model",  rx_data,  m_rdata);
      chk("R8", "rx_stop model",  rx_stop,  m_rb8);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic line(input logic val, input int n);
    int k;
    @(negedge clk);
    rx_drv = val;
    k = 0;
    while (k < n) begin
      @(posedge clk);
      if (baud_tick) k++;
    end
  endtask

  task automatic rx_bit(input logic val, input int glitch_at);
    if (glitch_at < 0) line(val, 16);
    else begin
      line(val, glitch_at);
      line(!val, 1);
      line(val, 15 - glitch_at);
    end
  endtask

  task automatic rx_frame(input logic [7:0] d, input logic stop, input bit glitch);
    rx_bit(1'b0, glitch ? 7 : -1);
    for (int i = 0; i < 8; i++) rx_bit(d[i], glitch ? (7 + (i % 3)) : -1);
    rx_bit(stop, -1);
    line(1'b1, 20);
  endtask

  task automatic pulse_take();
    @(negedge clk); rx_take = 1'b1;
    @(negedge clk); rx_take = 1'b0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (WD_LIM) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "txd", txd, 1);
    chk("R1", "tx_ready", tx_ready, 1);
    chk("R1", "tx_done", tx_done, 0);
    chk("R1", "rx_valid", rx_valid, 0);
    chk("R1", "rx_data", rx_data, 8'h00);
    chk("R1", "rx_stop", rx_stop, 0);

    line(1'b1, 4);
    // R5 / R8: plain frame, started by a falling edge after high samples
    rx_frame(8'h5A, 1'b1, 1'b0);
    chk("R5", "frame started", rx_valid, 1);
    chk("R8", "rx_data", rx_data, 8'h5A);
    chk("R8", "rx_stop", rx_stop, 1);

    // R9: full holder drops the next frame
    rx_frame(8'h11, 1'b1, 1'b0);
    chk("R9", "rx_data kept", rx_data, 8'h5A);
    chk("R9", "rx_valid", rx_valid, 1);

    // R12: take clears
    pulse_take();
    chk("R12", "rx_valid cleared", rx_valid, 0);

    // R6: one odd sample per bit
    rx_frame(8'hC3, 1'b1, 1'b1);
    chk("R6", "majority data", rx_data, 8'hC3);
    pulse_take();

    // R7: short low pulse, then start whose votes read 0,1,1
    line(1'b0, 4);  line(1'b1, 30);
    line(1'b0, 8);  line(1'b1, 30);
    chk("R7", "no frame after false starts", rx_valid, 0);
    rx_frame(8'h96, 1'b1, 1'b0);
    chk("R7", "realigned data", rx_data, 8'h96);
    pulse_take();

    // R10: filter on
    addr_filter = 1'b1;
    rx_frame(8'h44, 1'b0, 1'b0);
    chk("R10", "low stop dropped", rx_valid, 0);
    chk("R10", "data unchanged", rx_data, 8'h96);
    rx_frame(8'h45, 1'b1, 1'b0);
    chk("R10", "high stop kept", rx_data, 8'h45);
    chk("R10", "rx_stop", rx_stop, 1);
    pulse_take();
    addr_filter = 1'b0;
    rx_frame(8'h46, 1'b0, 1'b0);
    chk("R8", "low stop kept unfiltered", rx_data, 8'h46);
    chk("R8", "rx_stop low", rx_stop, 0);
    pulse_take();

    // R11: stop bit cut after its decision, line held low without a high sample
    rx_bit(1'b0, -1);
    for (int i = 0; i < 8; i++) rx_bit(1'(8'h21 >> i), -1);
    line(1'b1, 10);
    line(1'b0, 40);
    chk("R11", "first frame", rx_data, 8'h21);
    pulse_take();
    line(1'b1, 20);
    chk("R11", "no frame from unarmed low", rx_valid, 0);
    rx_frame(8'h77, 1'b1, 1'b0);
    chk("R11", "next frame aligned", rx_data, 8'h77);
    pulse_take();

    // R2 / R3 / R4 over loopback
    @(negedge clk); loop_en = 1'b1;
    @(negedge clk); tx_valid = 1'b1; tx_data = 8'hA5;
    @(negedge clk); tx_valid = 1'b0;
    chk("R2", "ready low after accept", tx_ready, 0);
    tx_valid = 1'b1; tx_data = 8'h3C;
    repeat (3) @(negedge clk);
    tx_valid = 1'b0;
    while (!tx_done) @(negedge clk);
    chk("R4", "ready with done", tx_ready, 1);
    chk("R3", "txd idle high", txd, 1);
    chk("R2", "busy write ignored", rx_data, 8'hA5);
    chk("R3", "loopback valid", rx_valid, 1);
    tx_done_clr = 1'b1;
    @(negedge clk); tx_done_clr = 1'b0;
    chk("R12", "tx_done cleared", tx_done, 0);
    pulse_take();
    @(negedge clk); tx_valid = 1'b1; tx_data = 8'h0F;
    @(negedge clk); tx_valid = 1'b0;
    while (!tx_done) @(negedge clk);
    chk("R3", "second loopback", rx_data, 8'h0F);
    @(negedge clk); loop_en = 1'b0;
    repeat (10) @(negedge clk);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule